// File: doc/BRIEF.md
# Serial Receive Status Controller

This block holds the receive half of a byte-wide serial port's register set. A bit-level deserializer hands it finished characters on a one-cycle strobe, with a parity-error qualifier. The block stores each character in a data register and keeps the receive status flags: data full, overrun, framing error and parity error. It drives a receive interrupt, which is a one-cycle pulse, and a receive-error interrupt, which is a level.

Software works through a small register bus. It can read or write a control register. It can read the status register or clear error flags in it, and it can read the data register. A separate frame timer tells the block when one full frame time has passed. The block will not take a second character before that. A line-break input marks a framing error directly.

Register map (reg_addr): 0 = control, 1 = status, 2 = receive data, 3 = unused (reads 0x00). Control bit 0 is the receiver enable and bit 1 is the receive-interrupt enable. Status bit 7 and bit 2 always read 1. Status bit 6 is data full, bit 5 overrun, bit 4 framing error and bit 3 parity error. Bits 1 and 0 read 0.

Top module: `rx_status_ctrl`

## Requirements
- R1: After reset the status register reads 0x84, the data register reads 0x00, control reads 0x00, and both interrupts are low.
- R2: rx_ready is high only when control bit 0 is set and the frame gate is open. A strobe while rx_ready is low changes no register and no interrupt.
- R3: An accepted character closes the frame gate (rx_ready low from the next cycle). Only a frame_done pulse reopens it. The gate is open after reset.
- R4: An accepted character that arrives with data full clear is stored and sets data full. If control bit 1 is set, irq_rx is high for exactly the one cycle after the accepting edge.
- R5: An accepted character that arrives with data full set leaves the data register unchanged and sets overrun. If control bit 1 is set, irq_err rises and stays high.
- R6: A read of the data register returns the stored byte and clears data full.
- R7: A break_in pulse sets the framing-error flag and, if control bit 1 is set, raises irq_err.
- R8: A stored character that carries rx_perr sets the parity-error flag.
- R9: A status write clears each error flag (bits 5, 4, 3) whose written bit is 0 and keeps each one whose written bit is 1. Bits 7, 6 and 2 are not affected.
- R10: A status read records whether any error flag was set. irq_err falls on a later status write that leaves all error flags zero, but only if that record is set. Without such a read, the write leaves irq_err high.
- R11: A control write with bit 1 clear drops irq_err at the next edge.
- R12: Writes to the data register change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_en | input | 1 | Register access strobe, one cycle per access |
| reg_wr | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr, combinational |
| rx_valid | input | 1 | Character strobe from the deserializer |
| rx_byte | input | 8 | Received character |
| rx_perr | input | 1 | Parity error on this character |
| frame_done | input | 1 | One frame time has elapsed |
| break_in | input | 1 | Line-break detected |
| rx_ready | output | 1 | Block will accept a character |
| irq_rx | output | 1 | Receive interrupt pulse |
| irq_err | output | 1 | Receive-error interrupt level |

## Verification
Every register effect (flags, data, gate, snapshot) takes effect at the clock edge that samples the access or strobe. It is therefore visible on reg_rdata and rx_ready one edge later. irq_rx and irq_err are registered, so each is due in the cycle right after that edge. irq_rx must be gone again one cycle later. The bench applies each stimulus in one cycle only and idles the next. At the following falling edge it compares the status and data registers through the combinational read port, with reg_en low so the comparison has no side effects. It also compares both interrupts and rx_ready against a model that is updated from the state before the edge.

// File: rtl/rx_status_ctrl.sv
module rx_status_ctrl #(
  parameter int DW = 8,
  parameter int AW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_en,
  input  logic          reg_wr,
  input  logic [AW-1:0] reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic          rx_valid,
  input  logic [DW-1:0] rx_byte,
  input  logic          rx_perr,
  input  logic          frame_done,
  input  logic          break_in,
  output logic          rx_ready,
  output logic          irq_rx,
  output logic          irq_err
);
  localparam logic [AW-1:0] ADR_CTRL = AW'(0);
  localparam logic [AW-1:0] ADR_STAT = AW'(1);
  localparam logic [AW-1:0] ADR_DATA = AW'(2);

  logic          ren_q, rie_q, gap_q, full_q, ovr_q, fer_q, per_q, snap_q;
  logic          irq_rx_q, irq_err_q;
  logic [DW-1:0] data_q;

  wire rd      = reg_en & ~reg_wr;
  wire wr      = reg_en &  reg_wr;
  wire wr_ctrl = wr & (reg_addr == ADR_CTRL);
  wire wr_stat = wr & (reg_addr == ADR_STAT);
  wire rd_stat = rd & (reg_addr == ADR_STAT);
  wire rd_data = rd & (reg_addr == ADR_DATA);

  assign rx_ready = ren_q & gap_q;
  wire accept = rx_valid & rx_ready;
  wire store  = accept & ~full_q;
  wire ovrun  = accept &  full_q;

  wire ovr_n = (wr_stat ? (ovr_q & reg_wdata[5]) : ovr_q) | ovrun;
  wire fer_n = (wr_stat ? (fer_q & reg_wdata[4]) : fer_q) | break_in;
  wire per_n = (wr_stat ? (per_q & reg_wdata[3]) : per_q) | (store & rx_perr);
  wire err_set = rie_q & (ovrun | break_in);
  wire err_clr = wr_stat & snap_q & ~(ovr_n | fer_n | per_n);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ren_q     <= 1'b0;
      rie_q     <= 1'b0;
      gap_q     <= 1'b1;
      full_q    <= 1'b0;
      ovr_q     <= 1'b0;
      fer_q     <= 1'b0;
      per_q     <= 1'b0;
      snap_q    <= 1'b0;
      irq_rx_q  <= 1'b0;
      irq_err_q <= 1'b0;
      data_q    <= '0;
    end else begin
      if (wr_ctrl) begin
        ren_q <= reg_wdata[0];
        rie_q <= reg_wdata[1];
      end
      if (accept)          gap_q <= 1'b0;
      else if (frame_done) gap_q <= 1'b1;
      if (store)           data_q <= rx_byte;
      if (store)           full_q <= 1'b1;
      else if (rd_data)    full_q <= 1'b0;
      ovr_q <= ovr_n;
      fer_q <= fer_n;
      per_q <= per_n;
      if (rd_stat) snap_q <= ovr_q | fer_q | per_q;
      irq_rx_q <= store & rie_q;
      if (wr_ctrl && !reg_wdata[1]) irq_err_q <= 1'b0;
      else if (err_set)             irq_err_q <= 1'b1;
      else if (err_clr)             irq_err_q <= 1'b0;
    end
  end

  assign irq_rx  = irq_rx_q;
  assign irq_err = irq_err_q;

  always_comb begin
    unique case (reg_addr)
      ADR_CTRL: reg_rdata = {{(DW-2){1'b0}}, rie_q, ren_q};
      ADR_STAT: reg_rdata = DW'({1'b1, full_q, ovr_q, fer_q, per_q, 1'b1, 2'b00});
      ADR_DATA: reg_rdata = data_q;
      default:  reg_rdata = '0;
    endcase
  end

  // R4
  rx_pulse_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_rx |-> full_q);
  // R4
  rx_pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_rx |=> !irq_rx);
  // R3
  gate_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_ready) |=> !rx_ready);
  // R5
  ovr_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_ready && full_q) |=> ($stable(data_q) && ovr_q));
  // R12
  data_wr_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && reg_addr == ADR_DATA && !(rx_valid && rx_ready)) |=> $stable(data_q));
  // R11
  rie_off_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && !reg_wdata[1]) |=> !irq_err);
  // R7
  brk_fer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    break_in |=> fer_q);
endmodule

// File: tb/test_rx_status_ctrl.sv
`timescale 1ns/1ps
module test_rx_status_ctrl;
  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_en = 0, reg_wr = 0;
  logic [1:0] reg_addr = 0;
  logic [7:0] reg_wdata = 0, reg_rdata, rx_byte = 0;
  logic rx_valid = 0, rx_perr = 0, frame_done = 0, break_in = 0;
  logic rx_ready, irq_rx, irq_err;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  rx_status_ctrl i_rx_status_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_en(reg_en), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .rx_valid(rx_valid), .rx_byte(rx_byte), .rx_perr(rx_perr),
    .frame_done(frame_done), .break_in(break_in), .rx_ready(rx_ready),
    .irq_rx(irq_rx), .irq_err(irq_err));

  // model state
  bit m_ren, m_rie, m_gap = 1, m_full, m_ovr, m_fer, m_per, m_snap, m_ie, m_irx;
  logic [7:0] m_data = 8'h00;

  function automatic logic [7:0] m_stat();
    return {1'b1, m_full, m_ovr, m_fer, m_per, 1'b1, 2'b00};
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic check_all(input string ts, input string td, input string te, input string tr);
    reg_en = 0; reg_addr = 2'd1; #0.2;
    chk(ts, reg_rdata, m_stat());
    reg_addr = 2'd2; #0.2;
    chk(td, reg_rdata, m_data);
    chk("R4 irq_rx", {7'b0, irq_rx}, {7'b0, m_irx});
    chk(te, {7'b0, irq_err}, {7'b0, m_ie});
    chk(tr, {7'b0, rx_ready}, {7'b0, m_ren & m_gap});
  endtask

  // ops: 0 rx, 1 frame_done, 2 break, 3 rd stat, 4 rd data, 5 wr stat, 6 wr ctrl, 7 wr data
  task automatic do_op(input int op, input logic [7:0] v, input bit pe);
    string ts, td, te, tr;
    ts = "R9 status"; td = "R6 data"; te = "R10 irq_err"; tr = "R2 ready";
    @(negedge clk);
    m_irx = 0;
    case (op)
      0: begin
        rx_valid = 1; rx_byte = v; rx_perr = pe;
        ts = "R8 status"; td = "R4 data"; te = "R5 irq_err"; tr = "R3 ready";
        if (m_ren && m_gap) begin
          m_gap = 0;
          if (m_full) begin m_ovr = 1; if (m_rie) m_ie = 1; ts = "R5 status"; td = "R5 data"; end
          else begin m_data = v; m_full = 1; if (pe) m_per = 1; m_irx = m_rie; end
        end else begin ts = "R2 status"; td = "R2 data"; te = "R2 irq_err"; end
      end
      1: begin frame_done = 1; m_gap = 1; tr = "R3 ready"; end
      2: begin break_in = 1; m_fer = 1; if (m_rie) m_ie = 1; ts = "R7 status"; te = "R7 irq_err"; end
      3: begin reg_en = 1; reg_wr = 0; reg_addr = 2'd1; m_snap = m_ovr | m_fer | m_per; end
      4: begin reg_en = 1; reg_wr = 0; reg_addr = 2'd2; m_full = 0; ts = "R6 status"; end
      5: begin
        reg_en = 1; reg_wr = 1; reg_addr = 2'd1; reg_wdata = v;
        m_ovr &= v[5]; m_fer &= v[4]; m_per &= v[3];
        if (m_snap && !(m_ovr | m_fer | m_per)) m_ie = 0;
      end
      6: begin
        reg_en = 1; reg_wr = 1; reg_addr = 2'd0; reg_wdata = v;
        m_ren = v[0]; m_rie = v[1]; if (!v[1]) m_ie = 0; te = "R11 irq_err";
      end
      default: begin reg_en = 1; reg_wr = 1; reg_addr = 2'd2; reg_wdata = v; td = "R12 data"; ts = "R12 status"; end
    endcase
    @(negedge clk);
    reg_en = 0; reg_wr = 0; rx_valid = 0; rx_perr = 0; frame_done = 0; break_in = 0;
    check_all(ts, td, te, tr);
  endtask

  initial begin
    #400000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1357_2468));
    #12 rst_n = 1;
    @(negedge clk);
    // R1 reset values
    check_all("R1 status", "R1 data", "R1 irq_err", "R1 ready");
    reg_addr = 2'd0; #0.2; chk("R1 ctrl", reg_rdata, 8'h00);
    // R2: disabled receiver drops strobe
    do_op(0, 8'h5a, 0);
    // enable, interrupts on
    do_op(6, 8'h03, 0);
    do_op(0, 8'ha5, 1);          // R4, R8
    do_op(0, 8'h11, 0);          // R3 gate closed
    do_op(1, 0, 0);
    do_op(0, 8'h22, 0);          // R5 overrun keeps a5
    do_op(7, 8'hee, 0);          // R12
    do_op(5, 8'h00, 0);          // R10 no snapshot: irq_err stays
    do_op(2, 0, 0);              // R7
    do_op(3, 0, 0);
    do_op(5, 8'h00, 0);          // R10 falls
    do_op(4, 0, 0);              // R6
    do_op(2, 0, 0);
    do_op(6, 8'h01, 0);          // R11
    do_op(6, 8'h03, 0);
    do_op(3, 0, 0);
    do_op(5, 8'hff, 0);          // R9 keep
    do_op(5, 8'h28, 0);          // R9 partial clear
    for (int i = 0; i < 3000; i++) begin
      int op;
      op = int'($urandom_range(0, 9));
      if (op > 7) op = (op == 8) ? 0 : 1;
      do_op(op, 8'($urandom), 1'($urandom));
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule